// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block is the front end of a stored-program accumulator machine. Program and data share one read/write memory of 1000 words. Every 40-bit memory word carries two 20-bit instructions, and each instruction is an 8-bit opcode followed by a 12-bit address. The sequencer keeps a program counter and a memory address register, and reads a word through the shared memory port. It latches the word into a memory buffer register, sends the left instruction to the instruction register and parks the right instruction in an instruction buffer. It then hands one opcode/address pair at a time to the execute stage over a valid/ready handshake.

When the buffer still holds the right half, the next fetch takes it from the buffer and does not touch memory. The program counter advances one word only after the right half has been issued, and it wraps from 999 back to 0. The execute stage can redirect the sequencer with a branch request. The request gives a target word and picks the left or the right half. A right-half branch reads the target word and issues only its right instruction.

Top module: `twin_fetch`

## Requirements
- R1: While reset is asserted, and after its release, `mem_rd_en` and `iss_valid` are low. The first memory read after reset addresses word 0.
- R2: A fetched word is split as left opcode in bits 39:32, left address in 31:20, right opcode in 19:12 and right address in 11:0. The left instruction issues first (`iss_right`=0) and the right one after it (`iss_right`=1).
- R3: Each memory word is read exactly once per visit. The right instruction is issued from the instruction buffer with no further memory read.
- R4: A read is a one-cycle `mem_rd_en` pulse. The data comes back on `mem_rdata` in the following cycle and then appears on `fetched_word` for every instruction issued from that word.
- R5: While `iss_valid` is high and `iss_ready` is low, with no branch, `iss_valid`, `iss_opcode`, `iss_addr` and `iss_right` hold their values.
- R6: The program counter advances by one word only after a right instruction is accepted. From word 999 it wraps to word 0.
- R7: A branch with `br_right`=0 discards any buffered right instruction and continues fetching at the target word. It issues that word's left instruction, then its right instruction.
- R8: A branch with `br_right`=1 reads the target word and issues only its right instruction. Fetching then continues with the left instruction of the next word.
- R9: A branch target of 1000 or above is reduced by 1000 before use.
- R10: A branch takes priority over a pending issue or a read in flight. That issue or read is dropped, and the next instruction issued comes from the branch target.
- R11: Every memory read address is below 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 10 | Memory word address (driven by the address register) |
| mem_rdata | input | 40 | Read data, valid one cycle after the strobe |
| fetched_word | output | 40 | Memory buffer register contents |
| iss_valid | output | 1 | An instruction is offered to execute |
| iss_ready | input | 1 | Execute accepts the offered instruction |
| iss_opcode | output | 8 | Opcode of the offered instruction |
| iss_addr | output | 12 | Address field of the offered instruction |
| iss_right | output | 1 | 1 when the offered instruction is a right half |
| br_valid | input | 1 | Branch request, one cycle |
| br_target | input | 10 | Branch target word |
| br_right | input | 1 | 1 selects the right half of the target word |

## Verification
The assertions check on every cycle that reads stay in range and last one cycle, and that a held offer does not change. They also check that a left-half offer always has a valid buffered right half behind it, that the counter steps with wrap on each right retirement, and that a branch empties the buffer. Other behaviours need the bench's scenarios: the exact order of the instruction stream, that no word is read twice, how right-half and out-of-range branches land, and branches that arrive while an offer is stalled or a read is in flight. The bench's behavioural model tracks these on every clock.

// File: rtl/twin_fetch_pkg.sv
package twin_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_READ,
    ST_DECODE,
    ST_ISSUE
  } fetch_st_t;

  // Reduce a branch target into the memory range (targets stay below 2*depth).
  function automatic int unsigned fold_addr(int unsigned a, int unsigned depth);
    if (a >= depth) return a - depth;
    return a;
  endfunction

  // Sequential successor of a word address, wrapping at the top of memory.
  function automatic int unsigned next_seq(int unsigned a, int unsigned depth);
    if (a + 1 >= depth) return 0;
    return a + 1;
  endfunction

endpackage

// File: rtl/twin_fetch_pc.sv
module twin_fetch_pc #(
  parameter int MEM_DEPTH = 1000,
  parameter int PC_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] load_addr,
  input  logic            adv,
  input  logic            mar_load,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] mar_q
);
  import twin_fetch_pkg::*;

  logic [PC_W-1:0] load_folded;
  logic [PC_W-1:0] pc_succ;

  assign load_folded = PC_W'(fold_addr(int'(unsigned'(load_addr)), MEM_DEPTH));
  assign pc_succ     = PC_W'(next_seq(int'(unsigned'(pc_q)), MEM_DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (load) begin
      pc_q <= load_folded;
    end else if (adv) begin
      pc_q <= pc_succ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q <= '0;
    end else if (mar_load) begin
      mar_q <= pc_q;
    end
  end

endmodule

// File: rtl/twin_fetch_bufs.sv
module twin_fetch_bufs #(
  parameter int WORD_W = 40,
  parameter int OP_W   = 8,
  parameter int AD_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [WORD_W-1:0] word_in,
  input  logic              flush,
  input  logic              flush_right,
  input  logic              take_ibr,
  output logic [WORD_W-1:0] mbr_q,
  output logic [OP_W-1:0]   ir_op,
  output logic [AD_W-1:0]   ir_ad,
  output logic              ir_right,
  output logic              ibr_valid,
  output logic              skip_pend
);
  localparam int INS_W = OP_W + AD_W;

  logic [OP_W-1:0] ibr_op;
  logic [AD_W-1:0] ibr_ad;

  function automatic logic [OP_W-1:0] left_op(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: OP_W];
  endfunction
  function automatic logic [AD_W-1:0] left_ad(input logic [WORD_W-1:0] w);
    return w[WORD_W-OP_W-1 -: AD_W];
  endfunction
  function automatic logic [OP_W-1:0] right_op(input logic [WORD_W-1:0] w);
    return w[INS_W-1 -: OP_W];
  endfunction
  function automatic logic [AD_W-1:0] right_ad(input logic [WORD_W-1:0] w);
    return w[AD_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbr_q     <= '0;
      ir_op     <= '0;
      ir_ad     <= '0;
      ir_right  <= 1'b0;
      ibr_op    <= '0;
      ibr_ad    <= '0;
      ibr_valid <= 1'b0;
      skip_pend <= 1'b0;
    end else if (flush) begin
      ibr_valid <= 1'b0;
      skip_pend <= flush_right;
    end else if (cap) begin
      mbr_q     <= word_in;
      skip_pend <= 1'b0;
      if (skip_pend) begin
        ir_op     <= right_op(word_in);
        ir_ad     <= right_ad(word_in);
        ir_right  <= 1'b1;
        ibr_valid <= 1'b0;
      end else begin
        ir_op     <= left_op(word_in);
        ir_ad     <= left_ad(word_in);
        ir_right  <= 1'b0;
        ibr_op    <= right_op(word_in);
        ibr_ad    <= right_ad(word_in);
        ibr_valid <= 1'b1;
      end
    end else if (take_ibr) begin
      ir_op     <= ibr_op;
      ir_ad     <= ibr_ad;
      ir_right  <= 1'b1;
      ibr_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/twin_fetch_fsm.sv
module twin_fetch_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic br_valid,
  input  logic iss_ready,
  input  logic ibr_valid,
  input  logic ir_right,
  output logic mar_load,
  output logic rd_en,
  output logic cap,
  output logic take_ibr,
  output logic iss_valid,
  output logic adv
);
  import twin_fetch_pkg::*;

  fetch_st_t st_q;
  fetch_st_t st_d;
  logic      fire;

  always_comb begin
    st_d = st_q;
    if (br_valid) begin
      st_d = ST_ADDR;
    end else begin
      case (st_q)
        ST_IDLE:   st_d = ST_ADDR;
        ST_ADDR:   st_d = ibr_valid ? ST_ISSUE : ST_READ;
        ST_READ:   st_d = ST_DECODE;
        ST_DECODE: st_d = ST_ISSUE;
        ST_ISSUE:  st_d = iss_ready ? ST_ADDR : ST_ISSUE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign iss_valid = (st_q == ST_ISSUE);
  assign fire      = iss_valid && iss_ready;
  assign rd_en     = (st_q == ST_READ);
  assign cap       = (st_q == ST_DECODE) && !br_valid;
  assign take_ibr  = (st_q == ST_ADDR) && ibr_valid && !br_valid;
  assign mar_load  = (st_q == ST_ADDR) && !ibr_valid && !br_valid;
  assign adv       = fire && ir_right && !br_valid;

endmodule

// File: rtl/twin_fetch.sv
module twin_fetch #(
  parameter  int WORD_W    = 40,
  parameter  int OP_W      = 8,
  parameter  int MEM_DEPTH = 1000,
  localparam int INS_W     = WORD_W / 2,
  localparam int AD_W      = INS_W - OP_W,
  localparam int PC_W      = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd_en,
  output logic [PC_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] fetched_word,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [OP_W-1:0]   iss_opcode,
  output logic [AD_W-1:0]   iss_addr,
  output logic              iss_right,
  input  logic              br_valid,
  input  logic [PC_W-1:0]   br_target,
  input  logic              br_right
);

  // Named internal events, visible to the bound checker.
  logic            mar_load_evt;
  logic            cap_evt;
  logic            take_ibr_evt;
  logic            adv_evt;
  logic            ibr_vld;
  logic            skip_pend;
  logic [PC_W-1:0] pc_q;

  twin_fetch_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_valid  (br_valid),
    .iss_ready (iss_ready),
    .ibr_valid (ibr_vld),
    .ir_right  (iss_right),
    .mar_load  (mar_load_evt),
    .rd_en     (mem_rd_en),
    .cap       (cap_evt),
    .take_ibr  (take_ibr_evt),
    .iss_valid (iss_valid),
    .adv       (adv_evt)
  );

  twin_fetch_pc #(
    .MEM_DEPTH (MEM_DEPTH),
    .PC_W      (PC_W)
  ) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (br_valid),
    .load_addr (br_target),
    .adv       (adv_evt),
    .mar_load  (mar_load_evt),
    .pc_q      (pc_q),
    .mar_q     (mem_addr)
  );

  twin_fetch_bufs #(
    .WORD_W (WORD_W),
    .OP_W   (OP_W),
    .AD_W   (AD_W)
  ) u_bufs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap         (cap_evt),
    .word_in     (mem_rdata),
    .flush       (br_valid),
    .flush_right (br_right),
    .take_ibr    (take_ibr_evt),
    .mbr_q       (fetched_word),
    .ir_op       (iss_opcode),
    .ir_ad       (iss_addr),
    .ir_right    (iss_right),
    .ibr_valid   (ibr_vld),
    .skip_pend   (skip_pend)
  );

endmodule

// File: rtl/twin_fetch_chk.sv
module twin_fetch_chk #(
  parameter int MEM_DEPTH = 1000,
  parameter int PC_W      = 10,
  parameter int OP_W      = 8,
  parameter int AD_W      = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_rd_en,
  input logic [PC_W-1:0] mem_addr,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [OP_W-1:0] iss_opcode,
  input logic [AD_W-1:0] iss_addr,
  input logic            iss_right,
  input logic            br_valid,
  input logic [PC_W-1:0] pc_q,
  input logic            ibr_vld,
  input logic            adv_evt,
  input logic            cap_evt,
  input logic            skip_pend
);

  a_r11_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (int'(unsigned'(mem_addr)) < MEM_DEPTH));

  a_r4_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  a_r5_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !br_valid) |=>
      (iss_valid && $stable(iss_opcode) && $stable(iss_addr) && $stable(iss_right)));

  a_r3_right_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_right) |-> ibr_vld);

  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (int'(unsigned'(pc_q)) ==
      ((int'(unsigned'($past(pc_q))) == MEM_DEPTH - 1) ? 0 : int'(unsigned'($past(pc_q))) + 1)));

  a_r7_branch_flush: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !ibr_vld);

  a_r8_right_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && skip_pend) |=> (iss_right && !ibr_vld));

endmodule

bind twin_fetch twin_fetch_chk #(
  .MEM_DEPTH (MEM_DEPTH),
  .PC_W      (PC_W),
  .OP_W      (OP_W),
  .AD_W      (AD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .iss_opcode (iss_opcode),
  .iss_addr   (iss_addr),
  .iss_right  (iss_right),
  .br_valid   (br_valid),
  .pc_q       (pc_q),
  .ibr_vld    (ibr_vld),
  .adv_evt    (adv_evt),
  .cap_evt    (cap_evt),
  .skip_pend  (skip_pend)
);

// File: tb/twin_fetch_bench.sv
module twin_fetch_bench;
  localparam int WORD_W = 40;
  localparam int OP_W   = 8;
  localparam int AD_W   = 12;
  localparam int PC_W   = 10;
  localparam int DEPTH  = 1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mem_rd_en;
  logic [PC_W-1:0]   mem_addr;
  logic [WORD_W-1:0] mem_rdata = '0;
  logic [WORD_W-1:0] fetched_word;
  logic              iss_valid;
  logic              iss_ready = 1'b0;
  logic [OP_W-1:0]   iss_opcode;
  logic [AD_W-1:0]   iss_addr;
  logic              iss_right;
  logic              br_valid = 1'b0;
  logic [PC_W-1:0]   br_target = '0;
  logic              br_right = 1'b0;

  int compared = 0;
  int mismatched = 0;
  int fire_cnt = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  string cur_req = "R2";

  // model state
  int pc_m = 0;
  bit half_m = 0;
  bit word_read = 0;
  bit first_read = 1;
  bit prev_rd = 0;
  bit prev_hold = 0;
  logic [OP_W-1:0] prev_op;
  logic [AD_W-1:0] prev_ad;
  logic prev_rt;

  always #4 clk = ~clk;

  twin_fetch u_twin_fetch (
    .clk (clk), .rst_n (rst_n),
    .mem_rd_en (mem_rd_en), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
    .fetched_word (fetched_word),
    .iss_valid (iss_valid), .iss_ready (iss_ready),
    .iss_opcode (iss_opcode), .iss_addr (iss_addr), .iss_right (iss_right),
    .br_valid (br_valid), .br_target (br_target), .br_right (br_right)
  );

  function automatic logic [WORD_W-1:0] mem_word(int a);
    int lo = a * 7 + 3;
    int la = a * 3 + 11;
    int ro = a * 5 + 1;
    int ra = a * 13 + 2;
    return {lo[7:0], la[11:0], ro[7:0], ra[11:0]};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory with one-cycle read latency.
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(int'(mem_addr));

  // Ready pattern generator.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0: iss_ready = 1'b1;
      1: iss_ready = lfsr[0];
      default: iss_ready = lfsr[0] & lfsr[3];
    endcase
  end

  // Behavioural reference model, stepped every clock between edges.
  always @(negedge clk) begin
    if (!rst_n) begin
      check(!iss_valid && !mem_rd_en, "R1", "outputs in reset", {iss_valid, mem_rd_en}, 0);
    end else begin
      check(!(prev_rd && mem_rd_en), "R4", "read strobe width", mem_rd_en, 0);
      prev_rd = mem_rd_en;
      if (prev_hold) begin
        check(iss_valid && iss_opcode == prev_op && iss_addr == prev_ad && iss_right == prev_rt,
              "R5", "held offer", {iss_valid, iss_opcode, iss_addr}, {1'b1, prev_op, prev_ad});
      end
      prev_hold = iss_valid && !iss_ready && !br_valid;
      prev_op = iss_opcode; prev_ad = iss_addr; prev_rt = iss_right;
      if (mem_rd_en) begin
        if (first_read) check(mem_addr == 0, "R1", "first read address", mem_addr, 0);
        first_read = 0;
        check(int'(mem_addr) < DEPTH, "R11", "read address range", mem_addr, DEPTH - 1);
        check(int'(mem_addr) == pc_m, "R3", "read address", mem_addr, pc_m);
        check(!word_read, "R3", "repeated read of word", pc_m, 0);
        word_read = 1;
      end
      if (iss_valid && iss_ready) begin
        logic [WORD_W-1:0] w;
        logic [OP_W-1:0] eo;
        logic [AD_W-1:0] ea;
        w = mem_word(pc_m);
        if (!half_m) begin eo = w[39:32]; ea = w[31:20]; end
        else begin eo = w[19:12]; ea = w[11:0]; end
        fire_cnt++;
        check(word_read, cur_req, "issue without read", 0, 1);
        check(iss_opcode == eo, cur_req, "opcode", iss_opcode, eo);
        check(iss_addr == ea, cur_req, "address field", iss_addr, ea);
        check(iss_right == half_m, cur_req, "half select", iss_right, half_m);
        check(fetched_word == w, "R4", "buffered word", fetched_word, w);
        if (!half_m) half_m = 1;
        else begin
          half_m = 0;
          pc_m = (pc_m + 1) % DEPTH;
          word_read = 0;
        end
      end
      if (br_valid) begin
        pc_m = int'(br_target) % DEPTH;
        half_m = br_right;
        word_read = 0;
      end
    end
  end

  task automatic wait_fires(int n, string req);
    int goal = fire_cnt + n;
    int t = 0;
    while (fire_cnt < goal && t < 3000) begin @(negedge clk); t++; end
    check(fire_cnt >= goal, req, "progress", fire_cnt, goal);
  endtask

  task automatic branch(int tgt, bit rt);
    @(posedge clk); #1;
    br_valid = 1'b1; br_target = PC_W'(tgt); br_right = rt;
    @(posedge clk); #1;
    br_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R2";  ready_mode = 0; wait_fires(10, "R2");
    cur_req = "R3";  ready_mode = 1; wait_fires(10, "R3");
    cur_req = "R7";  branch(500, 0); wait_fires(6, "R7");
    cur_req = "R8";  branch(20, 1);  wait_fires(3, "R8");
    cur_req = "R6";  ready_mode = 0; branch(998, 0); wait_fires(8, "R6");
    cur_req = "R9";  branch(1005, 1); wait_fires(3, "R9");
    cur_req = "R10"; ready_mode = 2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      while (!(iss_valid && !iss_ready)) @(negedge clk);
      branch(100 + 37 * k, k[0]);
      wait_fires(2, "R10");
      @(negedge clk);
      while (!mem_rd_en) @(negedge clk);
      branch(700 + 11 * k, !k[0]);
      wait_fires(3, "R10");
    end
    ready_mode = 1; wait_fires(6, "R10");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule